// File: doc/BRIEF.md
# Core Thread Run-Control Register Block

This block sits beside a multi-threaded processor core and gives a supervisor a small set of 64-bit registers for starting, stopping and soft-resetting each hardware thread. Accesses arrive on a plain register bus. Each cycle can carry a single-cycle read strobe or write strobe, a byte address and write data. The register word offset is the byte address shifted right by three. Every access covers a full aligned 64-bit word. Bits are numbered MSB-first, so MSB-0 bit n is bit 63-n of the port vectors.

A write to the control word holds one 8-bit command lane per thread. Each lane can carry a stop, start, soft-reset or clear-maintenance request. The block keeps a quiesced flag for each thread and turns the commands into registered one-cycle pause, resume and soft-reset pulses for the thread logic. It reports halted state, which arrives from outside, and its own quiesce state in two read-only words. Command bits it does not recognise are flagged. The bus has no back-pressure: every read returns its data, with a valid flag, in the cycle after the strobe.

Top module: `rc_core_runctl`

## Requirements
- R1: After reset every quiesced flag is clear, so a status read returns 0, and no pause, resume, soft-reset, error or unimplemented pulse is active.
- R2: A write to word offset 0x449 with MSB-0 bit 7+8i set (LSB bit 56-8i) sets the quiesced flag of thread i and pulses thr_pause[i] in the cycle after the write.
- R3: A start bit (MSB-0 6+8i, LSB 57-8i) or clear-maintenance bit (MSB-0 3+8i, LSB 60-8i) clears the quiesced flag of thread i and pulses thr_resume[i] in the cycle after the write.
- R4: A soft-reset bit (MSB-0 4+8i, LSB 59-8i) clears the quiesced flag of thread i and pulses thr_sreset[i] in the cycle after the write.
- R5: Commands within a lane take effect in the order stop, start, soft-reset, clear-maintenance. A lane that carries stop together with any clearing command leaves the thread not quiesced, and it still pulses both pause and the matching outputs.
- R6: A read of word offset 0x412 returns MSB-0 bit 56+i (LSB 7-i) equal to thr_halted[i]. It returns MSB-0 bit 62 (LSB 1) equal to one_part_mode. All other bits are 0.
- R7: A read of word offset 0x454 sets both MSB-0 bits 8i and 8i+1 (LSB 63-8i and 62-8i) for each quiesced thread i. All other bits are 0.
- R8: A read of word offset 0x413 returns 0 with no error.
- R9: A control write that has any set bit outside the recognised command bits of the implemented threads pulses cmd_unimp in the next cycle. The recognised bits in the same write still take effect.
- R10: A read of any other offset, a read of the control word, a misaligned read (byte address bits 2:0 not zero) and any write other than an aligned control write return 0 or are ignored, and pulse bus_err in the next cycle.
- R11: Every read strobe produces bus_rvalid, with its data on bus_rdata, in exactly the next cycle. Pulse outputs last one cycle for each write.
- R12: A lane with no command bits leaves its thread's quiesced flag unchanged and produces no pulse for that thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 64 | Write data, MSB-0 numbering |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid, else 0 |
| bus_rvalid | output | 1 | Read response, one cycle after bus_rd |
| bus_err | output | 1 | Undecoded or illegal access, one cycle after the strobe |
| cmd_unimp | output | 1 | Control write carried unrecognised bits |
| one_part_mode | input | 1 | One-partition-per-core option, reported in thread state |
| thr_halted | input | NT | Halted indication per thread |
| thr_pause | output | NT | Pause pulse per thread |
| thr_resume | output | NT | Resume pulse per thread |
| thr_sreset | output | NT | Soft-reset resume pulse per thread |

## Verification
The hardest states to reach are lanes that combine a stop with one or more clearing commands, and several threads that change in a single write while others keep their state. Random lanes seldom hit these combinations on purpose. The bench therefore drives directed writes for stop plus start, stop plus soft-reset, and an all-lanes-at-once write. It then sends random control words whose lanes are each built from a random subset of the four command bits, with stray bits sometimes added. A status read follows every write, so that the hidden quiesce flags show at the ports.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int WORD_W = 64;
  localparam int LANE_W = 8;
  localparam int OFF_W  = 12;

  localparam logic [OFF_W-1:0] OFF_THR_STATE = 12'h412;
  localparam logic [OFF_W-1:0] OFF_THR_INFO  = 12'h413;
  localparam logic [OFF_W-1:0] OFF_DIR_CTRL  = 12'h449;
  localparam logic [OFF_W-1:0] OFF_RAS_STAT  = 12'h454;

  // MSB-0 positions of the commands inside one lane
  localparam int POS_STOP   = 7;
  localparam int POS_START  = 6;
  localparam int POS_SRESET = 4;
  localparam int POS_CLRMNT = 3;

  localparam int POS_HALT_BASE = 56;
  localparam int POS_ONE_PART  = 62;

  typedef struct packed {
    logic stop;
    logic start;
    logic sreset;
    logic clrmnt;
  } lane_cmd_t;

  function automatic int lsb_of(input int msb0_pos);
    return WORD_W - 1 - msb0_pos;
  endfunction
endpackage

// File: rtl/rc_lane_decode.sv
module rc_lane_decode
  import rc_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic              wr_ctrl,
  input  logic [WORD_W-1:0] wdata,
  output lane_cmd_t         cmd,
  output logic [WORD_W-1:0] used_mask
);
  localparam int B_STOP   = lsb_of(POS_STOP   + LANE_W * LANE);
  localparam int B_START  = lsb_of(POS_START  + LANE_W * LANE);
  localparam int B_SRESET = lsb_of(POS_SRESET + LANE_W * LANE);
  localparam int B_CLRMNT = lsb_of(POS_CLRMNT + LANE_W * LANE);

  always_comb begin
    cmd.stop   = wr_ctrl & wdata[B_STOP];
    cmd.start  = wr_ctrl & wdata[B_START];
    cmd.sreset = wr_ctrl & wdata[B_SRESET];
    cmd.clrmnt = wr_ctrl & wdata[B_CLRMNT];
    used_mask = '0;
    used_mask[B_STOP]   = 1'b1;
    used_mask[B_START]  = 1'b1;
    used_mask[B_SRESET] = 1'b1;
    used_mask[B_CLRMNT] = 1'b1;
  end
endmodule

// File: rtl/rc_thread_ctl.sv
module rc_thread_ctl
  import rc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lane_cmd_t cmd,
  output logic      quiesced,
  output logic      pause_p,
  output logic      resume_p,
  output logic      sreset_p
);
  logic any_clear;
  logic any_cmd;
  logic q_next;

  // Ordered evaluation: stop first, then any clearing command overrides it
  always_comb begin
    any_clear = cmd.start | cmd.sreset | cmd.clrmnt;
    any_cmd   = cmd.stop | any_clear;
    q_next    = quiesced;
    if (cmd.stop)  q_next = 1'b1;
    if (any_clear) q_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiesced <= 1'b0;
      pause_p  <= 1'b0;
      resume_p <= 1'b0;
      sreset_p <= 1'b0;
    end else begin
      if (any_cmd) quiesced <= q_next;
      pause_p  <= cmd.stop;
      resume_p <= cmd.start | cmd.clrmnt;
      sreset_p <= cmd.sreset;
    end
  end
endmodule

// File: rtl/rc_status_mux.sv
module rc_status_mux
  import rc_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic              aligned,
  input  logic              hit_state,
  input  logic              hit_info,
  input  logic              hit_ras,
  input  logic              hit_ctrl,
  input  logic              one_part,
  input  logic [NT-1:0]     halted,
  input  logic [NT-1:0]     quiesced,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              err
);
  logic [WORD_W-1:0] state_word;
  logic [WORD_W-1:0] ras_word;
  logic [WORD_W-1:0] sel_word;
  logic              rd_ok;
  logic              wr_ok;

  always_comb begin
    state_word = '0;
    ras_word   = '0;
    for (int i = 0; i < NT; i++) begin
      state_word[lsb_of(POS_HALT_BASE + i)] = halted[i];
      ras_word[lsb_of(LANE_W * i)]          = quiesced[i];
      ras_word[lsb_of(LANE_W * i + 1)]      = quiesced[i];
    end
    state_word[lsb_of(POS_ONE_PART)] = one_part;
  end

  always_comb begin
    rd_ok = aligned & (hit_state | hit_info | hit_ras);
    wr_ok = aligned & hit_ctrl;
    sel_word = '0;
    if (rd_ok) begin
      if (hit_state)    sel_word = state_word;
      else if (hit_ras) sel_word = ras_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? sel_word : '0;
      err    <= (rd & ~rd_ok) | (wr & ~wr_ok);
    end
  end
endmodule

// File: rtl/rc_core_runctl.sv
module rc_core_runctl
  import rc_pkg::*;
#(
  parameter int NT = 4,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [63:0]   bus_wdata,
  output logic [63:0]   bus_rdata,
  output logic          bus_rvalid,
  output logic          bus_err,
  output logic          cmd_unimp,
  input  logic          one_part_mode,
  input  logic [NT-1:0] thr_halted,
  output logic [NT-1:0] thr_pause,
  output logic [NT-1:0] thr_resume,
  output logic [NT-1:0] thr_sreset
);
  localparam int WOFF_W = AW - 3;

  logic [WOFF_W-1:0] woff;
  logic              aligned;
  logic              hit_state, hit_info, hit_ras, hit_ctrl;
  logic              wr_ctrl;
  logic [NT-1:0]     quiesced;
  logic [WORD_W-1:0] lane_mask [NT];
  logic [WORD_W-1:0] all_used;

  initial begin
    if (NT < 1 || NT > 4) $error("NT must be 1..4");
    if (AW < 15) $error("AW too small for the decoded offsets");
  end

  assign woff      = bus_addr[AW-1:3];
  assign aligned   = (bus_addr[2:0] == 3'b000);
  assign hit_state = (woff == WOFF_W'(OFF_THR_STATE));
  assign hit_info  = (woff == WOFF_W'(OFF_THR_INFO));
  assign hit_ras   = (woff == WOFF_W'(OFF_RAS_STAT));
  assign hit_ctrl  = (woff == WOFF_W'(OFF_DIR_CTRL));
  assign wr_ctrl   = bus_wr & aligned & hit_ctrl;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    lane_cmd_t cmd;
    rc_lane_decode #(.LANE(t)) u_dec (
      .wr_ctrl  (wr_ctrl),
      .wdata    (bus_wdata),
      .cmd      (cmd),
      .used_mask(lane_mask[t])
    );
    rc_thread_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .quiesced(quiesced[t]),
      .pause_p (thr_pause[t]),
      .resume_p(thr_resume[t]),
      .sreset_p(thr_sreset[t])
    );
  end

  always_comb begin
    all_used = '0;
    for (int t = 0; t < NT; t++) all_used = all_used | lane_mask[t];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_unimp <= 1'b0;
    else        cmd_unimp <= wr_ctrl & (|(bus_wdata & ~all_used));
  end

  rc_status_mux #(.NT(NT)) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .aligned  (aligned),
    .hit_state(hit_state),
    .hit_info (hit_info),
    .hit_ras  (hit_ras),
    .hit_ctrl (hit_ctrl),
    .one_part (one_part_mode),
    .halted   (thr_halted),
    .quiesced (quiesced),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid),
    .err      (bus_err)
  );
endmodule

// File: rtl/rc_runctl_chk.sv
module rc_runctl_chk #(
  parameter int NT = 4,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [63:0]   bus_wdata,
  input logic [63:0]   bus_rdata,
  input logic          bus_rvalid,
  input logic          bus_err,
  input logic          cmd_unimp,
  input logic          one_part_mode,
  input logic [NT-1:0] thr_halted,
  input logic [NT-1:0] thr_pause,
  input logic [NT-1:0] thr_resume,
  input logic [NT-1:0] thr_sreset
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (bus_addr == AW'(16'h2248));

  p_rvalid_follows_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_err_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && bus_err) |-> (bus_rdata == 64'h0));

  p_unimp_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unimp |-> $past(bus_wr));

  for (genvar i = 0; i < NT; i++) begin : g_a
    p_pause_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[56-8*i]) |=> thr_pause[i]);

    p_resume_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[57-8*i]) |=> thr_resume[i]);

    p_sreset_after_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[59-8*i]) |=> thr_sreset[i]);

    p_pulse_needs_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_pause[i] || thr_resume[i] || thr_sreset[i]) |-> $past(ctrl_wr));

    p_ras_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> ($past(bus_addr) != AW'(16'h22A0)) ||
                     (bus_rdata[63-8*i] == bus_rdata[62-8*i]));
  end
endmodule

bind rc_core_runctl rc_runctl_chk #(.NT(NT), .AW(AW)) u_chk (.*);

// File: tb/test_rc_core_runctl.sv
module test_rc_core_runctl;
  localparam int NT = 4;
  localparam int AW = 16;
  localparam int CLK_PERIOD = 10;

  localparam logic [AW-1:0] A_STATE = AW'(16'h2090);
  localparam logic [AW-1:0] A_INFO  = AW'(16'h2098);
  localparam logic [AW-1:0] A_CTRL  = AW'(16'h2248);
  localparam logic [AW-1:0] A_RAS   = AW'(16'h22A0);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [63:0]   bus_wdata = '0;
  logic [63:0]   bus_rdata;
  logic          bus_rvalid, bus_err, cmd_unimp;
  logic          one_part_mode = 1'b0;
  logic [NT-1:0] thr_halted = '0;
  logic [NT-1:0] thr_pause, thr_resume, thr_sreset;

  int n_run = 0, n_fail = 0, cycles = 0;
  logic [NT-1:0] mq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rc_core_runctl #(.NT(NT), .AW(AW)) i_rc_core_runctl (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] lane_bits(input int i, input logic s, input logic st,
                                            input logic sr, input logic cm);
    logic [63:0] w = '0;
    w[56-8*i] = s; w[57-8*i] = st; w[59-8*i] = sr; w[60-8*i] = cm;
    return w;
  endfunction

  function automatic logic [63:0] exp_state(input logic [NT-1:0] h, input logic op);
    logic [63:0] w = '0;
    for (int i = 0; i < NT; i++) w[7-i] = h[i];
    w[1] = op;
    return w;
  endfunction

  function automatic logic [63:0] exp_ras(input logic [NT-1:0] q);
    logic [63:0] w = '0;
    for (int i = 0; i < NT; i++) begin w[63-8*i] = q[i]; w[62-8*i] = q[i]; end
    return w;
  endfunction

  function automatic logic [63:0] known_mask();
    logic [63:0] w = '0;
    for (int i = 0; i < NT; i++) w = w | lane_bits(i, 1, 1, 1, 1);
    return w;
  endfunction

  task automatic do_write(input string req, input logic [AW-1:0] a, input logic [63:0] d);
    logic [NT-1:0] ep = '0, er = '0, es = '0;
    logic ctrl = (a == A_CTRL);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (ctrl) for (int i = 0; i < NT; i++) begin
      logic s, st, sr, cm;
      s = d[56-8*i]; st = d[57-8*i]; sr = d[59-8*i]; cm = d[60-8*i];
      ep[i] = s; er[i] = st | cm; es[i] = sr;
      if (s) mq[i] = 1'b1;
      if (st | sr | cm) mq[i] = 1'b0;
    end
    @(posedge clk); #1;
    bus_wr = 1'b0;
    chk({req, " pause"},  64'(thr_pause),  64'(ep));
    chk({req, " resume"}, 64'(thr_resume), 64'(er));
    chk({req, " sreset"}, 64'(thr_sreset), 64'(es));
    chk({req, " err"},    64'(bus_err),    64'(!ctrl));
    chk({req, " unimp"},  64'(cmd_unimp),  64'(ctrl && |(d & ~known_mask())));
    @(posedge clk); #1;
    chk({req, " R11 pulse ends"}, 64'(thr_pause | thr_resume | thr_sreset), 64'h0);
  endtask

  task automatic do_read(input string req, input logic [AW-1:0] a,
                         input logic [63:0] exp, input logic exp_err);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    chk({req, " R11 rvalid"}, 64'(bus_rvalid), 64'h1);
    chk({req, " data"}, bus_rdata, exp);
    chk({req, " err"}, 64'(bus_err), 64'(exp_err));
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pause", 64'(thr_pause | thr_resume | thr_sreset), 64'h0);
    chk("R1 flags", 64'({bus_err, cmd_unimp, bus_rvalid}), 64'h0);
    @(negedge clk); rst_n = 1'b1;
    do_read("R1 ras", A_RAS, 64'h0, 1'b0);

    thr_halted = 4'b0101; one_part_mode = 1'b1;
    do_read("R6 state", A_STATE, exp_state(thr_halted, 1'b1), 1'b0);
    thr_halted = 4'b1010; one_part_mode = 1'b0;
    do_read("R6 state2", A_STATE, exp_state(thr_halted, 1'b0), 1'b0);
    do_read("R8 info", A_INFO, 64'h0, 1'b0);

    do_write("R2 stop t1", A_CTRL, lane_bits(1, 1, 0, 0, 0));
    do_read("R2 ras", A_RAS, exp_ras(mq), 1'b0);
    do_write("R12 idle lanes", A_CTRL, lane_bits(2, 1, 0, 0, 0));
    do_read("R12 ras", A_RAS, exp_ras(mq), 1'b0);
    do_write("R3 start t1", A_CTRL, lane_bits(1, 0, 1, 0, 0));
    do_read("R3 ras", A_RAS, exp_ras(mq), 1'b0);
    do_write("R3 clrmnt t2", A_CTRL, lane_bits(2, 0, 0, 0, 1));
    do_read("R3 ras2", A_RAS, exp_ras(mq), 1'b0);
    do_write("R2 all stop", A_CTRL, lane_bits(0,1,0,0,0) | lane_bits(1,1,0,0,0) |
                                     lane_bits(2,1,0,0,0) | lane_bits(3,1,0,0,0));
    do_read("R7 ras all", A_RAS, exp_ras(mq), 1'b0);
    do_write("R4 sreset t3", A_CTRL, lane_bits(3, 0, 0, 1, 0));
    do_read("R4 ras", A_RAS, exp_ras(mq), 1'b0);
    do_write("R5 stop+start t0", A_CTRL, lane_bits(0, 1, 1, 0, 0));
    do_read("R5 ras", A_RAS, exp_ras(mq), 1'b0);
    do_write("R5 stop+sreset t3", A_CTRL, lane_bits(3, 1, 0, 1, 0));
    do_read("R5 ras2", A_RAS, exp_ras(mq), 1'b0);
    do_write("R9 stray", A_CTRL, lane_bits(2, 1, 0, 0, 0) | 64'h8000_0000_0000_0001);
    do_read("R9 ras", A_RAS, exp_ras(mq), 1'b0);

    do_read("R10 ctrl read", A_CTRL, 64'h0, 1'b1);
    do_read("R10 undecoded", AW'(16'h0800), 64'h0, 1'b1);
    do_read("R10 misaligned", A_STATE | AW'(3), 64'h0, 1'b1);
    do_write("R10 ro write", A_RAS, 64'hFFFF_FFFF_FFFF_FFFF);
    do_write("R10 bad write", A_CTRL | AW'(4), lane_bits(0, 1, 0, 0, 0));
    do_read("R10 ras unchanged", A_RAS, exp_ras(mq), 1'b0);

    for (int k = 0; k < 300; k++) begin
      logic [63:0] d = '0;
      for (int i = 0; i < NT; i++) begin
        logic [3:0] r = 4'($urandom);
        if ($urandom % 3 != 0) d = d | lane_bits(i, r[0], r[1], r[2], r[3]);
      end
      if ($urandom % 5 == 0) d = d | (64'(1) << ($urandom % 64));
      do_write("R5 random", A_CTRL, d);
      do_read("R7 random ras", A_RAS, exp_ras(mq), 1'b0);
      thr_halted = NT'($urandom); one_part_mode = 1'($urandom);
      do_read("R6 random state", A_STATE, exp_state(thr_halted, one_part_mode), 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule